// File: doc/BRIEF.md
# Serial EEPROM Byte-Run Reader

This block fetches a run of consecutive bytes, such as a stored hardware address, from a small serial EEPROM with an SPI-style four-wire port. The host gives a start offset, a byte count and a bit-delay, then pulses start. The block drives chip select (active low), the serial clock and serial data out, and samples serial data in. Each recovered byte appears on a data output together with a one-cycle valid strobe. A one-cycle done pulse marks the end of the run.

Every run begins with a wake-up sequence: chip select is held high while two full clock pulses are issued. The block then opens one chip-select transaction per byte. Each transaction carries the read code and an 8-bit address, and the address advances by one from each byte to the next. A status mode replaces the data run with a single status-register transaction. Every level on the serial lines is held for the programmed number of system cycles before the next change.

Top module: `sereep_reader`

## Requirements
- R1: After reset, and whenever idle, cs_n_o is 1, sck_o is 0 and mosi_o is 0. busy_o, byte_valid_o and done_o are 0 in that state.
- R2: When start_i is seen high while idle, busy_o is 1 from the next cycle. The run opens with four phases that have cs_n_o at 1 and sck_o at 1, 0, 1, 0, which gives exactly two clock pulses with chip select high.
- R3: Every phase of the serial lines lasts D system cycles. D is delay_i captured at start, and a captured value of 0 is taken as 1. The serial clock high time is therefore D cycles.
- R4: A data transaction shifts out the code 8'h03 and then the 8-bit byte address, both most significant bit first. Each bit is placed on mosi_o while sck_o is low and is held unchanged through the following high phase, so the device captures it on the rising edge.
- R5: After the command, 8 data bits are taken from miso_i, each at the end of a low clock phase, and assembled most significant bit first. byte_o carries the byte and byte_valid_o pulses for one cycle in the cycle where cs_n_o returns high.
- R6: After each byte, cs_n_o is 1 and sck_o is 0 for one phase of D cycles before the next transaction or the end of the run.
- R7: A count of N gives N transactions at addresses offset, offset+1, and so on up to offset+N-1. Addresses wrap modulo 256.
- R8: done_o pulses for one cycle, with busy_o already 0, exactly (4+49*N)*D cycles after the start edge. For N=0 this is 4*D cycles, and no transaction is made.
- R9: With status_i high at start, count_i is ignored and one transaction is made. It shifts out the code 8'h05 with no address, then reads one byte. done_o follows (4+33)*D cycles after start.
- R10: A start_i pulse while busy_o is 1 has no effect on the running transfer's addresses, data, timing or delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| status_i | input | 1 | Selects the status-register read instead of a data run |
| offset_i | input | 8 | First byte address |
| count_i | input | 8 | Number of bytes to read |
| delay_i | input | 8 | System cycles per serial phase (0 taken as 1) |
| miso_i | input | 1 | Serial data from the EEPROM |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the EEPROM |
| busy_o | output | 1 | Run in progress |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| byte_o | output | 8 | Last byte read |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
All results are tied to the start edge by a phase count. Byte k's strobe is due (4+49*k+48)*D cycles after start, or 36*D in status mode. done_o is due (4+49*N)*D cycles after start. Each serial clock high time is due exactly D cycles after its rising edge. The bench counts clock edges from the one that accepted start and samples every output on the falling system clock edge, so each comparison lands on the exact cycle the registered output first holds its new value. A device model in the bench supplies miso_i on each falling serial clock and logs the opcode and address of every transaction.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/sereep_timer.sv
module sereep_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             tick_o
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // phase lasts dly_i cycles: load dly_i-1, tick at zero
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = dly_i - DLY_W'(1);
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == '0);

  a_r3_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (dly_i != '0));
endmodule

// File: rtl/sereep_txsh.sv
module sereep_txsh #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = load_i | shift_i;
    if (load_i) sr_d = word_i;
    else        sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign msb_o = sr_q[W-1];

  a_r4_load_excl_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));
endmodule

// File: rtl/sereep_rxsh.sv
module sereep_rxsh #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sr_q, sr_d;

  // first bit received ends up in the most significant position
  assign sr_d = {sr_q[W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (shift_i) sr_q <= sr_d;
  end

  assign data_o = sr_q;
endmodule

// File: rtl/sereep_reader.sv
module sereep_reader
  import sereep_pkg::*;
#(
  parameter int                 DLY_W  = 8,
  parameter int                 CNT_W  = 8,
  parameter int                 ADDR_W = 8,
  parameter int                 DATA_W = 8,
  parameter int                 OPC_W  = 8,
  parameter logic [OPC_W-1:0]   RD_OP  = 8'h03,
  parameter logic [OPC_W-1:0]   ST_OP  = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              status_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              done_o
);
  localparam int CMD_W   = OPC_W + ADDR_W;
  localparam int BITS_MX = CMD_W + DATA_W;
  localparam int BC_W    = $clog2(BITS_MX + 1);
  localparam int WAKE_PH = 4;
  localparam int WK_W    = $clog2(WAKE_PH);

  seq_state_t        state_q, state_d;
  logic [WK_W-1:0]   wake_q, wake_d;
  logic [BC_W-1:0]   bitc_q, bitc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              stat_q, stat_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              valid_q, valid_d;
  logic              done_q, done_d;

  logic              tick, tmr_load, tmr_run;
  logic [DLY_W-1:0]  tmr_dly, dly_in;
  logic              tx_load, tx_shift, tx_msb, rx_shift;
  logic [CMD_W-1:0]  tx_word;
  logic [BC_W-1:0]   cmd_bits, last_bit;
  logic              accept;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign dly_in   = (delay_i == '0) ? DLY_W'(1) : delay_i;
  assign cmd_bits = stat_q ? BC_W'(OPC_W) : BC_W'(CMD_W);
  assign last_bit = cmd_bits + BC_W'(DATA_W - 1);
  assign tmr_run  = (state_q != ST_IDLE);
  assign tmr_dly  = accept ? dly_in : dly_q;
  assign tx_word  = stat_d ? {ST_OP, {ADDR_W{1'b0}}} : {RD_OP, addr_d};

  sereep_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (tmr_run),
    .load_i (tmr_load),
    .dly_i  (tmr_dly),
    .tick_o (tick)
  );

  sereep_txsh #(.W(CMD_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tx_load),
    .word_i  (tx_word),
    .shift_i (tx_shift),
    .msb_o   (tx_msb)
  );

  sereep_rxsh #(.W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (rx_shift),
    .bit_i   (miso_i),
    .data_o  (byte_o)
  );

  // sequencer next state
  always_comb begin
    state_d  = state_q;
    wake_d   = wake_q;
    bitc_d   = bitc_q;
    addr_d   = addr_q;
    left_d   = left_q;
    stat_d   = stat_q;
    dly_d    = dly_q;
    valid_d  = 1'b0;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_WAKE;
          wake_d   = '0;
          addr_d   = offset_i;
          left_d   = count_i;
          stat_d   = status_i;
          dly_d    = dly_in;
          tmr_load = 1'b1;
        end
      end
      ST_WAKE: begin
        if (tick) begin
          if (wake_q == WK_W'(WAKE_PH - 1)) begin
            if (stat_q || (left_q != '0)) begin
              state_d  = ST_LOW;
              bitc_d   = '0;
              tx_load  = 1'b1;
              tmr_load = 1'b1;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            wake_d   = wake_q + WK_W'(1);
            tmr_load = 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (tick) begin
          rx_shift = (bitc_q >= cmd_bits);
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          tmr_load = 1'b1;
          if (bitc_q == last_bit) begin
            state_d = ST_GAP;
            valid_d = 1'b1;
          end else begin
            state_d  = ST_LOW;
            tx_shift = (bitc_q < cmd_bits);
            bitc_d   = bitc_q + BC_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (!stat_q && (left_q > CNT_W'(1))) begin
            state_d  = ST_LOW;
            left_d   = left_q - CNT_W'(1);
            addr_d   = addr_q + ADDR_W'(1);
            bitc_d   = '0;
            tx_load  = 1'b1;
            tmr_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wake_q  <= '0;
      bitc_q  <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      stat_q  <= 1'b0;
      dly_q   <= DLY_W'(1);
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      bitc_q  <= bitc_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      stat_q  <= stat_d;
      dly_q   <= dly_d;
      valid_q <= valid_d;
      done_q  <= done_d;
    end
  end

  // line decode from registered state
  assign cs_n_o       = !((state_q == ST_LOW) || (state_q == ST_HIGH));
  assign sck_o        = (state_q == ST_HIGH) || ((state_q == ST_WAKE) && !wake_q[0]);
  assign mosi_o       = ((state_q == ST_LOW) || (state_q == ST_HIGH)) &&
                        (bitc_q < cmd_bits) && tx_msb;
  assign busy_o       = (state_q != ST_IDLE);
  assign byte_valid_o = valid_q;
  assign done_o       = done_q;

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && !sck_o && !mosi_o));
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  a_r6_cs_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> !sck_o);
  a_r5_valid_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> (cs_n_o && !sck_o && busy_o));
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !byte_valid_o));
  a_r10_delay_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(dly_q));
endmodule

// File: tb/sereep_reader_test.sv
module sereep_reader_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, status_i, miso_i;
  logic [7:0] offset_i, count_i, delay_i;
  logic       cs_n_o, sck_o, mosi_o, busy_o, byte_valid_o, done_o;
  logic [7:0] byte_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  localparam logic [7:0] STAT_VAL = 8'hC6;

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  sereep_reader uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
    .offset_i(offset_i), .count_i(count_i), .delay_i(delay_i), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .mosi_o(mosi_o), .busy_o(busy_o),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .done_o(done_o)
  );

  function automatic logic [7:0] memf(input logic [7:0] a);
    return (a * 8'd29) + 8'h5B;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  logic [15:0] sh;
  int rises, init_rises, ntr, t_rise, exp_d;
  bit active = 1'b0;
  logic [7:0] op_log [0:15];
  logic [7:0] ad_log [0:15];
  logic prev_cs, prev_sck;
  logic mdl_miso = 1'b0;
  assign miso_i = mdl_miso;

  always @(sck_o or cs_n_o) begin
    if (active) begin
      if (cs_n_o === 1'b1 && prev_cs === 1'b0) ntr = ntr + 1;
      if (cs_n_o === 1'b0 && prev_cs === 1'b1) begin rises = 0; sh = '0; end
      if (sck_o === 1'b1 && prev_sck === 1'b0) begin
        t_rise = cyc;
        if (cs_n_o) init_rises = init_rises + 1;
        else begin
          if (rises < 16) sh = {sh[14:0], mosi_o};
          rises = rises + 1;
          if (ntr < 16 && rises == 8)  op_log[ntr] = sh[7:0];
          if (ntr < 16 && rises == 16) ad_log[ntr] = sh[7:0];
        end
      end
      if (sck_o === 1'b0 && prev_sck === 1'b1) begin
        chk(cyc - t_rise == exp_d, "R3 sck high width", cyc - t_rise, exp_d);
        if (!cs_n_o && ntr < 16) begin
          if (op_log[ntr] == 8'h05 && rises >= 8 && rises < 16)
            mdl_miso = STAT_VAL[15 - rises];
          else if (op_log[ntr] == 8'h03 && rises >= 16 && rises < 24)
            mdl_miso = memf(ad_log[ntr])[23 - rises];
        end
      end
    end
    prev_cs  = cs_n_o;
    prev_sck = sck_o;
  end

  task automatic run(input bit st, input logic [7:0] off, input logic [7:0] n,
                     input logic [7:0] dly, input bit poke);
    int d, nexp, per, pre, total, k, start_cyc;
    bit got;
    d     = (dly == 0) ? 1 : int'(dly);
    nexp  = st ? 1 : int'(n);
    per   = st ? 33 : 49;
    pre   = st ? 32 : 48;
    total = 4 + per * nexp;
    k     = 0;
    got   = 1'b0;
    @(negedge clk);
    ntr = 0; init_rises = 0; rises = 0; exp_d = d; active = 1'b1;
    start_i = 1'b1; status_i = st; offset_i = off; count_i = n; delay_i = dly;
    @(negedge clk);
    start_i = 1'b0;
    start_cyc = cyc;
    chk(busy_o && cs_n_o && sck_o, "R2 start accepted, wake phase", {busy_o, cs_n_o, sck_o}, 3'b111);
    for (int c = 0; c < 20000 && !got; c++) begin
      @(negedge clk);
      if (byte_valid_o) begin
        logic [7:0] eb;
        eb = st ? STAT_VAL : memf(off + 8'(k));
        chk(byte_o == eb, st ? "R9 status byte" : "R5 data byte", byte_o, eb);
        chk(cyc == start_cyc + (4 + per * k + pre) * d, "R5 strobe cycle",
            cyc - start_cyc, (4 + per * k + pre) * d);
        chk(cs_n_o && !sck_o, "R6 cs high clk low after byte", {cs_n_o, sck_o}, 2'b10);
        k++;
      end
      if (done_o) begin
        chk(cyc == start_cyc + total * d, st ? "R9 done cycle" : "R8 done cycle",
            cyc - start_cyc, total * d);
        chk(!busy_o, "R8 busy low at done", busy_o, 0);
        got = 1'b1;
      end
      if (poke && c == 6) begin
        start_i = 1'b1; offset_i = off + 8'h40; count_i = 8'd2;
        delay_i = dly + 8'd1; status_i = !st;
      end else start_i = 1'b0;
    end
    if (!got) chk(1'b0, "R8 done never seen", 0, 1);
    chk(k == nexp, poke ? "R10 byte count with stray start" : "R7 byte count", k, nexp);
    chk(ntr == nexp, "R7 transaction count", ntr, nexp);
    chk(init_rises == 2, "R2 wake clock pulses", init_rises, 2);
    for (int t = 0; t < nexp && t < 16; t++) begin
      logic [7:0] eo;
      eo = st ? 8'h05 : 8'h03;
      chk(op_log[t] == eo, st ? "R9 status opcode" : "R4 read opcode", op_log[t], eo);
      if (!st) chk(ad_log[t] == off + 8'(t), "R7 address with wrap", ad_log[t], off + 8'(t));
    end
    chk(cs_n_o && !sck_o && !mosi_o, "R1 idle lines after run", {cs_n_o, sck_o, mosi_o}, 3'b100);
    active = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; status_i = 1'b0;
    offset_i = '0; count_i = '0; delay_i = '0;
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sck_o && !mosi_o && !busy_o && !byte_valid_o && !done_o,
        "R1 reset state", {cs_n_o, sck_o, mosi_o, busy_o, byte_valid_o, done_o}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 4; d++)
      for (int n = 0; n < 6; n++)
        run(1'b0, 8'hFB + 8'(d), 8'(n), 8'(d), 1'b0);
    run(1'b1, 8'h00, 8'd9, 8'd1, 1'b0);
    run(1'b1, 8'h22, 8'd0, 8'd3, 1'b0);
    run(1'b0, 8'h7E, 8'd3, 8'd2, 1'b1);
    run(1'b1, 8'h10, 8'd4, 8'd1, 1'b1);
    run(1'b0, 8'hFF, 8'd2, 8'd1, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule